// File: doc/BRIEF.md
# SMBus Fault Alert Controller

This block owns the shared active-low alert line of a bus-multiplexer-style device. It watches two fault sources: a grouped source, formed from downstream connection faults together with alert inputs arriving on downstream buses that are not currently connected, and a dedicated stuck-low timeout source. Each source latches a flag on its rising edge and pulls the alert line low. A latched source cannot pull the line low again until software clears it.

The alert line is released by the slave interface in two cases: when the device answers the Alert Response Address with its own address, and when the master addresses the device. Writing any data byte to the read-only status register (register 0) clears every latched flag. The status register also shows the live alert level of each downstream bus. Bus timing, the downstream switches and the SMBus shifter sit outside this block and reach it only as level and strobe inputs.

Top module: `smbAlertCtl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `alertN` is 1 and both latched fault bits of `statusReg` are 0.
- R2: When `connFault` rises and the grouped flag is clear, `alertN` goes to 0 and `statusReg[NUM_BUS]` (the grouped flag) goes to 1 at the next clock edge.
- R3: A low `busAlertN[i]` on a bus whose `busConnected[i]` is 0 feeds the grouped source as in R2. A low `busAlertN[i]` on a connected bus does not feed it.
- R4: When `stuckLow` rises and the stuck flag is clear, `alertN` goes to 0 and `statusReg[NUM_BUS+1]` (the stuck flag) goes to 1 at the next clock edge.
- R5: `alertN` falls only at an edge where a latched flag newly sets. A fault that persists, or rises again while its flag is set, leaves a released alert high.
- R6: After a release, a rising edge on the other source, whose flag is clear, pulls `alertN` low again.
- R7: Once the stuck flag is set, it stays set until a `reg0Write` pulse, and further `stuckLow` edges are ignored.
- R8: A one-cycle `araReplied` pulse sets `alertN` to 1 at the next edge.
- R9: A one-cycle `addressed` pulse sets `alertN` to 1 at the next edge.
- R10: A `reg0Write` pulse clears both latched flags at the next edge and leaves `alertN` unchanged. A later rising edge of the same fault then fires again.
- R11: `statusReg[i]` for i below NUM_BUS equals the live `busAlertN[i]`, so 0 means bus i reports a fault.
- R12: If a firing fault edge and a release pulse arrive in the same cycle, the fault wins and `alertN` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| connFault | input | 1 | Downstream connection fault level |
| busAlertN | input | NUM_BUS | Per-bus downstream alert levels, active low |
| busConnected | input | NUM_BUS | Per-bus connection state, 1 = connected |
| stuckLow | input | 1 | Stuck-low timeout level |
| araReplied | input | 1 | Strobe: device answered the Alert Response Address |
| addressed | input | 1 | Strobe: device was addressed by the master |
| reg0Write | input | 1 | Strobe: data byte written to register 0 |
| alertN | output | 1 | Alert line, 0 = pull low |
| statusReg | output | NUM_BUS+2 | Register 0: bus alert levels, grouped flag, stuck flag |

## Verification
The grouped source is driven in two ways: by the connection-fault level alone, and by downstream alerts on connected and on unconnected buses. This shows that only orphaned alerts reach the trigger. Each source is held high across a release, and pulsed again while latched, to show the difference between edge-qualified firing and level retriggering. It is pulsed again after a clear to show that recurrence re-arms it. Mixed sequences, where one source fires after the other has been released, and same-cycle fault and release events, show that fault types are tracked separately and that a new fault takes priority.

// File: rtl/smbAlertPkg.sv
package smbAlertPkg;
  typedef struct packed {
    logic latchGroup;
    logic latchStuck;
    logic clearAll;
  } ctlStrobe_t;
endpackage

// File: rtl/smbAlertDatapath.sv
module smbAlertDatapath
  import smbAlertPkg::*;
#(
  parameter int NUM_BUS = 4,
  localparam int STAT_W = NUM_BUS + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               connFault,
  input  logic [NUM_BUS-1:0] busAlertN,
  input  logic [NUM_BUS-1:0] busConnected,
  input  logic               stuckLow,
  input  ctlStrobe_t         strobe,
  output logic               groupRise,
  output logic               stuckRise,
  output logic               groupFlag,
  output logic               stuckFlag,
  output logic [STAT_W-1:0]  statusReg
);
  logic [NUM_BUS-1:0] orphanAlert;
  logic groupSrc, groupPrev, stuckPrev;

  // An alert only counts when its bus is not switched through to the master.
  for (genvar i = 0; i < NUM_BUS; i++) begin : g_orphan
    assign orphanAlert[i] = ~busAlertN[i] & ~busConnected[i];
  end

  assign groupSrc  = connFault | (|orphanAlert);
  assign groupRise = groupSrc & ~groupPrev;
  assign stuckRise = stuckLow & ~stuckPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      groupPrev <= 1'b0;
      stuckPrev <= 1'b0;
      groupFlag <= 1'b0;
      stuckFlag <= 1'b0;
    end else begin
      groupPrev <= groupSrc;
      stuckPrev <= stuckLow;
      if (strobe.latchGroup)    groupFlag <= 1'b1;
      else if (strobe.clearAll) groupFlag <= 1'b0;
      if (strobe.latchStuck)    stuckFlag <= 1'b1;
      else if (strobe.clearAll) stuckFlag <= 1'b0;
    end
  end

  assign statusReg = {stuckFlag, groupFlag, busAlertN};
endmodule

// File: rtl/smbAlertControl.sv
module smbAlertControl
  import smbAlertPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       groupRise,
  input  logic       stuckRise,
  input  logic       groupFlag,
  input  logic       stuckFlag,
  input  logic       araReplied,
  input  logic       addressed,
  input  logic       reg0Write,
  output ctlStrobe_t strobe,
  output logic       alertN
);
  logic fireGroup, fireStuck, alertActive;

  // A source is armed while its flag is clear.
  assign fireGroup = groupRise & ~groupFlag;
  assign fireStuck = stuckRise & ~stuckFlag;

  always_comb begin
    strobe.latchGroup = fireGroup;
    strobe.latchStuck = fireStuck;
    strobe.clearAll   = reg0Write;
  end

  always_ff @(posedge clk) begin
    if (rst)                          alertActive <= 1'b0;
    else if (fireGroup || fireStuck)  alertActive <= 1'b1;
    else if (araReplied || addressed) alertActive <= 1'b0;
  end

  assign alertN = ~alertActive;
endmodule

// File: rtl/smbAlertCtl.sv
module smbAlertCtl
  import smbAlertPkg::*;
#(
  parameter int NUM_BUS = 4,
  localparam int STAT_W = NUM_BUS + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               connFault,
  input  logic [NUM_BUS-1:0] busAlertN,
  input  logic [NUM_BUS-1:0] busConnected,
  input  logic               stuckLow,
  input  logic               araReplied,
  input  logic               addressed,
  input  logic               reg0Write,
  output logic               alertN,
  output logic [STAT_W-1:0]  statusReg
);
  ctlStrobe_t strobe;
  logic groupRise, stuckRise, groupFlag, stuckFlag;

  smbAlertDatapath #(.NUM_BUS(NUM_BUS)) u_dp (
    .clk(clk), .rst(rst), .connFault(connFault), .busAlertN(busAlertN),
    .busConnected(busConnected), .stuckLow(stuckLow), .strobe(strobe),
    .groupRise(groupRise), .stuckRise(stuckRise), .groupFlag(groupFlag),
    .stuckFlag(stuckFlag), .statusReg(statusReg)
  );

  smbAlertControl u_ctl (
    .clk(clk), .rst(rst), .groupRise(groupRise), .stuckRise(stuckRise),
    .groupFlag(groupFlag), .stuckFlag(stuckFlag), .araReplied(araReplied),
    .addressed(addressed), .reg0Write(reg0Write), .strobe(strobe),
    .alertN(alertN)
  );
endmodule

// File: rtl/smbAlertChecker.sv
module smbAlertChecker #(
  parameter int NUM_BUS = 4,
  localparam int STAT_W = NUM_BUS + 2,
  localparam int GBIT = NUM_BUS,
  localparam int SBIT = NUM_BUS + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              araReplied,
  input logic              addressed,
  input logic              reg0Write,
  input logic              alertN,
  input logic [STAT_W-1:0] statusReg
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (alertN && !statusReg[GBIT] && !statusReg[SBIT]));

  // R5
  fall_needs_latch_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(alertN) |-> ($rose(statusReg[GBIT]) || $rose(statusReg[SBIT])));

  // R7
  stuck_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (statusReg[SBIT] && !reg0Write) |=> statusReg[SBIT]);

  // R10
  clear_source_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(statusReg[GBIT]) || $fell(statusReg[SBIT])) |-> $past(reg0Write));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (araReplied || addressed) |=>
      (alertN || $rose(statusReg[GBIT]) || $rose(statusReg[SBIT])));

  // R2
  group_alert_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(statusReg[GBIT]) |-> !alertN);
endmodule

bind smbAlertCtl smbAlertChecker #(.NUM_BUS(NUM_BUS)) u_chk (
  .clk(clk), .rst(rst), .araReplied(araReplied), .addressed(addressed),
  .reg0Write(reg0Write), .alertN(alertN), .statusReg(statusReg)
);

// File: tb/sim_smbAlertCtl.sv
module sim_smbAlertCtl;
  localparam int NB = 4;
  localparam int GB = NB;
  localparam int SB = NB + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic connFault = 1'b0, stuckLow = 1'b0;
  logic araReplied = 1'b0, addressed = 1'b0, reg0Write = 1'b0;
  logic [NB-1:0] busAlertN = '1;
  logic [NB-1:0] busConnected = '0;
  logic alertN;
  logic [NB+1:0] statusReg;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  smbAlertCtl #(.NUM_BUS(NB)) u0 (
    .clk(clk), .rst(rst), .connFault(connFault), .busAlertN(busAlertN),
    .busConnected(busConnected), .stuckLow(stuckLow), .araReplied(araReplied),
    .addressed(addressed), .reg0Write(reg0Write), .alertN(alertN),
    .statusReg(statusReg)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; step(); s = 1'b0;
  endtask

  task automatic doReset();
    connFault = 0; stuckLow = 0; araReplied = 0; addressed = 0; reg0Write = 0;
    busAlertN = '1; busConnected = '0;
    rst = 1; step(2); rst = 0; step();
  endtask

  task automatic testReset();
    doReset();
    check("R1 alertN", alertN, 1);
    check("R1 status", statusReg, 6'b001111);
  endtask

  task automatic testGroup();
    doReset();
    connFault = 1; step();
    check("R2 alertN", alertN, 0);
    check("R2 group flag", statusReg[GB], 1);
    pulse(addressed);
    check("R9 release by address", alertN, 1);
    step(3);
    check("R5 persisting fault", alertN, 1);
    connFault = 0; step(); connFault = 1; step();
    check("R5 re-rise while latched", alertN, 1);
    pulse(reg0Write);
    check("R10 flag cleared", statusReg[GB], 0);
    check("R10 alert unchanged", alertN, 1);
    connFault = 0; step(); connFault = 1; step();
    check("R10 recurrence fires", alertN, 0);
    pulse(araReplied);
    check("R8 release by ARA", alertN, 1);
  endtask

  task automatic testOrphan();
    doReset();
    busConnected = 4'b0100; busAlertN = 4'b1011; step();
    check("R3 connected bus ignored", alertN, 1);
    check("R11 live bus bits", statusReg[NB-1:0], 4'b1011);
    check("R3 no group flag", statusReg[GB], 0);
    busAlertN = 4'b1001; step();
    check("R3 unconnected bus fires", alertN, 0);
    check("R3 group flag", statusReg[GB], 1);
  endtask

  task automatic testStuck();
    doReset();
    stuckLow = 1; step();
    check("R4 alertN", alertN, 0);
    check("R4 stuck flag", statusReg[SB], 1);
    pulse(araReplied);
    stuckLow = 0; step(); stuckLow = 1; step();
    check("R7 second stuck ignored", alertN, 1);
    check("R7 stuck flag kept", statusReg[SB], 1);
    connFault = 1; step();
    check("R6 other type fires", alertN, 0);
    pulse(addressed);
    pulse(reg0Write);
    check("R10 both flags cleared", statusReg[SB:GB], 2'b00);
    stuckLow = 0; step(); stuckLow = 1; step();
    check("R10 stuck recurrence fires", alertN, 0);
  endtask

  task automatic testSimultaneous();
    doReset();
    connFault = 1; addressed = 1; step(); addressed = 0;
    check("R12 fault beats release", alertN, 0);
  endtask

  initial begin
    testReset();
    testGroup();
    testOrphan();
    testStuck();
    testSimultaneous();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule